// File: doc/BRIEF.md
# Periodic Delay-Channel Trigger Scheduler

This block holds four programmable delay channels that let a converter sample without software help. Each channel counts strobes of a 2 kHz timebase, delivered on a one-cycle enable input. When its delay runs out, the channel expires. Each expiry raises a one-cycle trigger on a chosen subset of eight conversion slots. It also asks a chosen subset of delay channels to start again, and that subset may include the channel itself.

Each channel also carries a loop count, which makes it expire a fixed number of extra times before it stops. A chain mask lets one channel launch another. Setting a channel's own bit in its chain mask makes it free-run. Software writes one configuration word per channel. It then starts or halts channels through per-channel kick-set and kick-clear strobes. The analog converter and the bus decoding sit outside this block.

Top module: `dly_sched`

## Requirements
- R1: After synchronous reset, `slot_trig` and `chan_start` are zero, every channel is halted, and every configuration word is zero.
- R2: A channel started with delay D expires on the D-th `tick` strobe after the start. D is an 11-bit value, and 0 is treated as 1. A delay of 200 therefore gives one expiry every 100 ms of a 2 kHz timebase.
- R3: With loop count L (5 bits) and an empty chain mask, a started channel expires exactly L+1 times, D ticks apart, and then stays silent.
- R4: The cycle after the clock edge that samples an expiring tick, `slot_trig` is high for one cycle. Its value is the OR of the 8-bit slot masks of all channels expiring at that edge, with bit n driving slot n.
- R5: In that same cycle `chan_start` carries the OR of the 4-bit chain masks of the expiring channels, with bit n meaning channel n. Each channel named there reloads its delay and loop count at the next edge. A channel that names itself free-runs.
- R6: A channel named by several channels expiring at the same edge is started only once, so it runs a single series.
- R7: `kick_clr[n]` halts channel n at the next edge. It takes priority over `kick_set[n]` and over a chain restart in the same cycle, and a halted channel emits nothing.
- R8: A kick or a chain restart of a channel whose configuration word is all zeros is ignored, and that channel emits no pulse.
- R9: While `cfg_we` is high, the word on `cfg_delay`, `cfg_loops`, `cfg_slots` and `cfg_chain` is stored for channel `cfg_idx` at the clock edge. A kick uses the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe of the 2 kHz timebase |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Channel addressed by the write |
| cfg_delay | input | 11 | Delay in ticks |
| cfg_loops | input | 5 | Extra expiries before the channel stops |
| cfg_slots | input | 8 | Slots triggered on expiry |
| cfg_chain | input | 4 | Delay channels restarted on expiry |
| kick_set | input | 4 | Start strobe per channel |
| kick_clr | input | 4 | Halt strobe per channel |
| slot_trig | output | 8 | Slot trigger pulses |
| chan_start | output | 4 | Delay-channel restart pulses |

## Verification
The hardest case to reach is two channels that expire at the same edge and both name a third channel. For that, two channels with equal delays are kicked by one strobe. The bench then checks three things: the merged slot and restart pulses, that the third channel fires after its own delay, and that it fires only once. Free-running through the self bit is checked over several periods before a kick-clear stops it. A 200-tick delay covers the period boundary.

// File: rtl/dly_pkg.sv
package dly_pkg;
    localparam int NUM_CH  = 4;
    localparam int NUM_SLT = 8;
    localparam int DLY_W   = 11;
    localparam int LOOP_W  = 5;

    typedef struct packed {
        logic [NUM_CH-1:0]  chain;
        logic [NUM_SLT-1:0] slots;
        logic [LOOP_W-1:0]  loops;
        logic [DLY_W-1:0]   delay;
    } dly_cfg_t;

    // Delay zero behaves as one tick
    function automatic logic at_end(input logic [DLY_W-1:0] cnt);
        return (cnt >> 1) == '0;
    endfunction
endpackage

// File: rtl/dly_channel.sv
module dly_channel
    import dly_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     cfg_we,
    input  dly_cfg_t cfg_in,
    input  logic     kick_set,
    input  logic     kick_clr,
    input  logic     restart,
    output logic     expire,
    output dly_cfg_t cfg_q
);
    logic              active_q;
    logic [DLY_W-1:0]  count_q;
    logic [LOOP_W-1:0] loops_q;
    logic              start;

    assign start  = (kick_set | restart) && (cfg_q != '0);
    assign expire = active_q && tick && at_end(count_q) && !kick_clr && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            active_q <= 1'b0;
            count_q  <= '0;
            loops_q  <= '0;
        end else begin
            if (cfg_we)
                cfg_q <= cfg_in;
            if (kick_clr) begin
                active_q <= 1'b0;
            end else if (start) begin
                active_q <= 1'b1;
                count_q  <= cfg_q.delay;
                loops_q  <= cfg_q.loops;
            end else if (active_q && tick) begin
                if (at_end(count_q)) begin
                    if (loops_q != '0) begin
                        loops_q <= loops_q - 1'b1;
                        count_q <= cfg_q.delay;
                    end else begin
                        active_q <= 1'b0;
                    end
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
        end
    end

    // R7
    halt_chk: assert property (@(posedge clk) disable iff (rst)
        kick_clr |=> !active_q);
    // R8
    idle_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q == '0 && !active_q) |=> !active_q);
    // R3
    loop_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && loops_q != '0) |=> (active_q && loops_q == $past(loops_q) - 1'b1));
    // R3
    loop_end_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && loops_q == '0) |=> !active_q);
endmodule

// File: rtl/dly_fanout.sv
module dly_fanout
    import dly_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_CH-1:0]               expire,
    input  logic [N_CH-1:0][NUM_SLT-1:0]  slot_masks,
    input  logic [N_CH-1:0][N_CH-1:0]     chain_masks,
    output logic [NUM_SLT-1:0]            slot_trig,
    output logic [N_CH-1:0]               chan_start
);
    logic [NUM_SLT-1:0] slot_d;
    logic [N_CH-1:0]    start_d;

    always_comb begin
        slot_d  = '0;
        start_d = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (expire[i]) begin
                slot_d  = slot_d | slot_masks[i];
                start_d = start_d | chain_masks[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_trig  <= '0;
            chan_start <= '0;
        end else begin
            slot_trig  <= slot_d;
            chan_start <= start_d;
        end
    end

    // R4
    slot_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|slot_trig) |-> $past(|expire));
    // R5
    start_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|chan_start) |-> $past(|expire));
    // R4
    slot_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (|slot_trig) |=> ((slot_trig & $past(slot_trig)) == '0 || $past(|expire)));
endmodule

// File: rtl/dly_sched.sv
module dly_sched
    import dly_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_idx,
    input  logic [DLY_W-1:0]    cfg_delay,
    input  logic [LOOP_W-1:0]   cfg_loops,
    input  logic [NUM_SLT-1:0]  cfg_slots,
    input  logic [NUM_CH-1:0]   cfg_chain,
    input  logic [NUM_CH-1:0]   kick_set,
    input  logic [NUM_CH-1:0]   kick_clr,
    output logic [NUM_SLT-1:0]  slot_trig,
    output logic [NUM_CH-1:0]   chan_start
);
    dly_cfg_t                        cfg_word;
    dly_cfg_t [NUM_CH-1:0]           cfg_bank;
    logic [NUM_CH-1:0]               expire;
    logic [NUM_CH-1:0][NUM_SLT-1:0]  slot_masks;
    logic [NUM_CH-1:0][NUM_CH-1:0]   chain_masks;

    assign cfg_word = '{chain: cfg_chain, slots: cfg_slots,
                        loops: cfg_loops, delay: cfg_delay};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dly_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .cfg_we   (cfg_we && cfg_idx == g),
            .cfg_in   (cfg_word),
            .kick_set (kick_set[g]),
            .kick_clr (kick_clr[g]),
            .restart  (chan_start[g]),
            .expire   (expire[g]),
            .cfg_q    (cfg_bank[g])
        );
        assign slot_masks[g]  = cfg_bank[g].slots;
        assign chain_masks[g] = cfg_bank[g].chain;
    end

    dly_fanout #(.N_CH(NUM_CH)) u_fan (
        .clk         (clk),
        .rst         (rst),
        .expire      (expire),
        .slot_masks  (slot_masks),
        .chain_masks (chain_masks),
        .slot_trig   (slot_trig),
        .chan_start  (chan_start)
    );

    // R1
    rst_out_chk: assert property (@(posedge clk)
        $past(rst) |-> (slot_trig == '0 && chan_start == '0));
endmodule

// File: tb/tb_dly_sched.sv
module tb_dly_sched;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [10:0] cfg_delay = '0;
    logic [4:0]  cfg_loops = '0;
    logic [7:0]  cfg_slots = '0;
    logic [3:0]  cfg_chain = '0;
    logic [3:0]  kick_set = '0;
    logic [3:0]  kick_clr = '0;
    logic [7:0]  slot_trig;
    logic [3:0]  chan_start;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dly_sched dut (.*);

    // {delay, loops, slots}
    localparam logic [23:0] VEC [5] = '{
        {11'd3, 5'd0, 8'h01},
        {11'd1, 5'd2, 8'hA5},
        {11'd5, 5'd1, 8'h80},
        {11'd0, 5'd3, 8'h3C},
        {11'd2, 5'd4, 8'hFF}
    };

    task automatic chk(input logic [7:0] s_exp, input logic [3:0] c_exp, input string tag);
        checks++;
        if (slot_trig !== s_exp || chan_start !== c_exp) begin
            errors++;
            $display("FAIL %s: slot_trig=%h chan_start=%h expected %h %h",
                     tag, slot_trig, chan_start, s_exp, c_exp);
        end
    endtask

    task automatic wcfg(input int idx, input int d, input int l, input int s, input int c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_delay = 11'(d);
        cfg_loops = 5'(l); cfg_slots = 8'(s); cfg_chain = 4'(c);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic kick(input logic [3:0] s, input logic [3:0] c);
        @(negedge clk);
        kick_set = s; kick_clr = c;
        @(negedge clk);
        kick_set = '0; kick_clr = '0;
    endtask

    // Drive one tick; on return the outputs for that tick are visible
    task automatic tick_once();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle2();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog: expired, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(8'h00, 4'h0, "R1 reset outputs");
        rst = 1'b0;
        @(negedge clk);
        chk(8'h00, 4'h0, "R1 after reset");

        // Table: single channel, no chain; R2 R3 R4 R9
        foreach (VEC[v]) begin
            int d, l, de;
            d  = int'(VEC[v][23:13]);
            l  = int'(VEC[v][12:8]);
            de = (d == 0) ? 1 : d;
            wcfg(0, d, l, int'(VEC[v][7:0]), 0);
            kick(4'b0001, 4'b0000);
            for (int t = 1; t <= (l + 2) * de; t++) begin
                logic fire;
                fire = (t % de == 0) && (t <= (l + 1) * de);
                tick_once();
                chk(fire ? VEC[v][7:0] : 8'h00, 4'h0, "R2 R3 R4 table series");
                idle2();
            end
        end

        // R8: zero config, kick ignored
        kick(4'b1000, 4'b0000);
        for (int t = 1; t <= 5; t++) begin
            tick_once();
            chk(8'h00, 4'h0, "R8 zero config idle");
            idle2();
        end

        // R7: clear halts running channel
        wcfg(0, 2, 31, 8'h11, 0);
        kick(4'b0001, 4'b0000);
        tick_once(); idle2();
        tick_once();
        chk(8'h11, 4'h0, "R7 fires before clear");
        idle2();
        kick(4'b0000, 4'b0001);
        for (int t = 1; t <= 6; t++) begin
            tick_once();
            chk(8'h00, 4'h0, "R7 halted after clear");
            idle2();
        end

        // R7: clear wins over set in same cycle
        kick(4'b0001, 4'b0001);
        for (int t = 1; t <= 4; t++) begin
            tick_once();
            chk(8'h00, 4'h0, "R7 clear beats set");
            idle2();
        end

        // R5: self chain free-run
        wcfg(1, 2, 0, 8'h02, 4'b0010);
        kick(4'b0010, 4'b0000);
        for (int t = 1; t <= 8; t++) begin
            tick_once();
            if (t % 2 == 0) chk(8'h02, 4'b0010, "R5 free-run");
            else            chk(8'h00, 4'h0, "R5 free-run gap");
            idle2();
        end
        kick(4'b0000, 4'b0010);
        for (int t = 1; t <= 4; t++) begin
            tick_once();
            chk(8'h00, 4'h0, "R7 free-run stopped");
            idle2();
        end

        // R6: two channels restart channel 2 at once
        wcfg(0, 2, 0, 8'h01, 4'b0100);
        wcfg(1, 2, 0, 8'h02, 4'b0100);
        wcfg(2, 3, 0, 8'h40, 4'b0000);
        kick(4'b0011, 4'b0000);
        for (int t = 1; t <= 10; t++) begin
            tick_once();
            if (t == 2)      chk(8'h03, 4'b0100, "R4 R5 merged expiry");
            else if (t == 5) chk(8'h40, 4'h0, "R6 chained single fire");
            else             chk(8'h00, 4'h0, "R6 no extra fire");
            idle2();
        end

        // R2: 200-tick delay boundary
        wcfg(3, 200, 0, 8'h08, 0);
        kick(4'b1000, 4'b0000);
        for (int t = 1; t <= 201; t++) begin
            tick_once();
            if (t == 199 || t == 200 || t == 201)
                chk(t == 200 ? 8'h08 : 8'h00, 4'h0, "R2 delay 200");
            idle2();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule